// File: doc/BRIEF.md
# Bus Master Security Filter

This block stands between a single bus master and the memory system below it. Each access that the master presents is judged by four inputs: two flags from an external region-attribution unit, and two static configuration bits. The judgement has exactly one of four results. The access may be forwarded with the secure attribute, forwarded with the non-secure attribute, refused with an error response, or refused silently, in which case reads return zero and writes are dropped.

A refusal with an error also sets a sticky violation flag, and that flag drives the interrupt output. A clear input resets the flag. While the clear input is held high, new violations cannot set the flag again.

Accesses are 1, 2, 4 or 8 bytes wide and use little-endian lanes. Only one access is handled at a time. The upstream side uses a request/ready handshake with a response pulse. The downstream side holds its request until the downstream response pulse arrives.

Top module: `master_sec_filter`

## Requirements
- R1: An access whose attribution flag `attr_exempt` is high is forwarded downstream. `dn_secure` is the inverse of `cfg_master_ns` as sampled at acceptance.
- R2: A non-exempt access with `attr_nonsec` high is forwarded with `dn_secure` low, whatever the value of `cfg_master_ns`.
- R3: A non-exempt access with `attr_nonsec` low is forwarded with `dn_secure` high when `cfg_master_ns` is low.
- R4: A non-exempt access with `attr_nonsec` low, `cfg_master_ns` high and `cfg_err_resp` low issues no downstream request. Its response has `up_err` low and `up_rdata` zero, and `irq` does not change.
- R5: The same access with `cfg_err_resp` high issues no downstream request and responds with `up_err` high. In the following cycle `irq` is high, unless `irq_clr` was high in the acceptance cycle.
- R6: `irq` is sticky. It stays high through later accesses until a cycle in which `irq_clr` is high, and is low from the next cycle. When `irq_clr` is high in the same cycle as a violation, `irq` stays low.
- R7: After reset `irq`, `dn_req` and `up_rsp_valid` are low and `up_ready` is high.
- R8: Size code n (0 to 3) means 2^n bytes. Byte k sits on bits [8k+7:8k]. `dn_addr`, `dn_wr` and `dn_size` equal the accepted upstream values. `dn_wdata` keeps only the bytes that the size covers, and the other bytes are zero. `up_rdata` is masked the same way.
- R9: For a forwarded access, `up_rsp_valid` is high in the cycle after `dn_rsp_valid`. It carries `dn_err` on `up_err` and the masked `dn_rdata`.
- R10: Only one access is in flight. A refused access responds in the cycle after acceptance. A forwarded access raises `dn_req` from the cycle after acceptance until `dn_rsp_valid`. `up_ready` stays low from acceptance until the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master_ns | input | 1 | Master is configured non-secure |
| cfg_err_resp | input | 1 | Refused accesses answer with error (else read-zero/write-drop) |
| irq_clr | input | 1 | Clears the violation flag, holding it high masks new violations |
| irq | output | 1 | Sticky violation interrupt |
| attr_exempt | input | 1 | Attribution: address is exempt from checking |
| attr_nonsec | input | 1 | Attribution: address lies in a non-secure region |
| up_req | input | 1 | Upstream access request |
| up_ready | output | 1 | Filter can accept a request |
| up_wr | input | 1 | Access is a write |
| up_addr | input | ADDR_W | Access address |
| up_size | input | SIZE_W | Size code, 2^n bytes |
| up_wdata | input | DATA_W | Write data |
| up_rsp_valid | output | 1 | Upstream response pulse |
| up_rdata | output | DATA_W | Read data |
| up_err | output | 1 | Error response |
| dn_req | output | 1 | Downstream request, held until response |
| dn_wr | output | 1 | Downstream write flag |
| dn_addr | output | ADDR_W | Downstream address |
| dn_size | output | SIZE_W | Downstream size code |
| dn_wdata | output | DATA_W | Downstream masked write data |
| dn_secure | output | 1 | Downstream secure attribute |
| dn_rsp_valid | input | 1 | Downstream response pulse |
| dn_rdata | input | DATA_W | Downstream read data |
| dn_err | input | 1 | Downstream error |

## Verification
A violation that sets the flag and a raised clear input can land in the same cycle. The bench provokes this by holding `irq_clr` high while an error-mode refused access is accepted. It then expects the error response together with `irq` staying low. It also clears a flag that is already set while later accesses are forwarded, and checks that the clear wins and that forwarding continues undisturbed. The sweep covers every combination of the four decision inputs, both directions and all four sizes. Each combination is judged against a decision table and a lane mask that the bench computes itself.

// File: rtl/msf_pkg.sv
package msf_pkg;
   typedef enum logic [1:0] {
      VERD_ABORT   = 2'd0,
      VERD_RAZWI   = 2'd1,
      VERD_PASS_S  = 2'd2,
      VERD_PASS_NS = 2'd3
   } verdict_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RESP = 2'd2
   } xfer_st_e;
endpackage

// File: rtl/msf_decide.sv
module msf_decide
   import msf_pkg::*;
(
   input  logic     exempt,
   input  logic     region_ns,
   input  logic     master_ns,
   input  logic     err_resp,
   output verdict_e verdict
);
   always_comb begin
      if (exempt)
         verdict = master_ns ? VERD_PASS_NS : VERD_PASS_S;
      else if (region_ns)
         verdict = VERD_PASS_NS;
      else if (!master_ns)
         verdict = VERD_PASS_S;
      else if (err_resp)
         verdict = VERD_ABORT;
      else
         verdict = VERD_RAZWI;
   end
endmodule

// File: rtl/msf_lane_mask.sv
module msf_lane_mask #(
   parameter int DATA_W = 64,
   parameter int SIZE_W = 2
) (
   input  logic [SIZE_W-1:0] size,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int LANES = DATA_W / 8;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic keep;
      assign keep = ((32'(g) >> size) == 32'd0);
      assign dout[g*8 +: 8] = keep ? din[g*8 +: 8] : 8'h00;
   end
endmodule

// File: rtl/msf_irq.sv
module msf_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic set,
   output logic status
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status <= 1'b0;
      else if (clr)
         status <= 1'b0;
      else if (set)
         status <= 1'b1;
   end
endmodule

// File: rtl/msf_xfer.sv
module msf_xfer
   import msf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int SIZE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_req,
   input  logic              up_wr,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [SIZE_W-1:0] up_size,
   input  logic [DATA_W-1:0] wdata_masked,
   input  verdict_e          verdict,
   output logic              up_ready,
   output logic              up_rsp_valid,
   output logic [DATA_W-1:0] up_rdata,
   output logic              up_err,
   output logic              violation,
   output logic              dn_req,
   output logic              dn_wr,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [SIZE_W-1:0] dn_size,
   output logic [DATA_W-1:0] dn_wdata,
   output logic              dn_secure,
   input  logic              dn_rsp_valid,
   input  logic [DATA_W-1:0] rdata_masked,
   input  logic              dn_err
);
   xfer_st_e st;
   logic     accept;

   assign accept       = (st == ST_IDLE) && up_req;
   assign up_ready     = (st == ST_IDLE);
   assign up_rsp_valid = (st == ST_RESP);
   assign dn_req       = (st == ST_WAIT);
   assign violation    = accept && (verdict == VERD_ABORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         up_rdata  <= '0;
         up_err    <= 1'b0;
         dn_wr     <= 1'b0;
         dn_addr   <= '0;
         dn_size   <= '0;
         dn_wdata  <= '0;
         dn_secure <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (up_req) begin
                  if (verdict == VERD_ABORT || verdict == VERD_RAZWI) begin
                     st       <= ST_RESP;
                     up_err   <= (verdict == VERD_ABORT);
                     up_rdata <= '0;
                  end else begin
                     st        <= ST_WAIT;
                     dn_wr     <= up_wr;
                     dn_addr   <= up_addr;
                     dn_size   <= up_size;
                     dn_wdata  <= wdata_masked;
                     dn_secure <= (verdict == VERD_PASS_S);
                  end
               end
            end
            ST_WAIT: begin
               if (dn_rsp_valid) begin
                  st       <= ST_RESP;
                  up_err   <= dn_err;
                  up_rdata <= rdata_masked;
               end
            end
            ST_RESP: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/master_sec_filter.sv
module master_sec_filter
   import msf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   localparam int LANES  = DATA_W / 8,
   localparam int SIZE_W = $clog2($clog2(LANES) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master_ns,
   input  logic              cfg_err_resp,
   input  logic              irq_clr,
   output logic              irq,
   input  logic              attr_exempt,
   input  logic              attr_nonsec,
   input  logic              up_req,
   output logic              up_ready,
   input  logic              up_wr,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [SIZE_W-1:0] up_size,
   input  logic [DATA_W-1:0] up_wdata,
   output logic              up_rsp_valid,
   output logic [DATA_W-1:0] up_rdata,
   output logic              up_err,
   output logic              dn_req,
   output logic              dn_wr,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [SIZE_W-1:0] dn_size,
   output logic [DATA_W-1:0] dn_wdata,
   output logic              dn_secure,
   input  logic              dn_rsp_valid,
   input  logic [DATA_W-1:0] dn_rdata,
   input  logic              dn_err
);
   if (DATA_W != 16 && DATA_W != 32 && DATA_W != 64) begin : g_bad_data_w
      $error("master_sec_filter: DATA_W must be 16, 32 or 64");
   end
   if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr_w
      $error("master_sec_filter: ADDR_W out of range");
   end

   verdict_e          verdict;
   logic              violation;
   logic [DATA_W-1:0] wdata_masked;
   logic [DATA_W-1:0] rdata_masked;

   msf_decide u_decide (
      .exempt    (attr_exempt),
      .region_ns (attr_nonsec),
      .master_ns (cfg_master_ns),
      .err_resp  (cfg_err_resp),
      .verdict   (verdict)
   );

   msf_lane_mask #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_wmask (
      .size (up_size),
      .din  (up_wdata),
      .dout (wdata_masked)
   );

   msf_lane_mask #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_rmask (
      .size (dn_size),
      .din  (dn_rdata),
      .dout (rdata_masked)
   );

   msf_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_xfer (
      .clk          (clk),
      .rst_n        (rst_n),
      .up_req       (up_req),
      .up_wr        (up_wr),
      .up_addr      (up_addr),
      .up_size      (up_size),
      .wdata_masked (wdata_masked),
      .verdict      (verdict),
      .up_ready     (up_ready),
      .up_rsp_valid (up_rsp_valid),
      .up_rdata     (up_rdata),
      .up_err       (up_err),
      .violation    (violation),
      .dn_req       (dn_req),
      .dn_wr        (dn_wr),
      .dn_addr      (dn_addr),
      .dn_size      (dn_size),
      .dn_wdata     (dn_wdata),
      .dn_secure    (dn_secure),
      .dn_rsp_valid (dn_rsp_valid),
      .rdata_masked (rdata_masked),
      .dn_err       (dn_err)
   );

   msf_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (irq_clr),
      .set    (violation),
      .status (irq)
   );
endmodule

// File: rtl/msf_checker.sv
module msf_checker (
   input logic clk,
   input logic rst_n,
   input logic cfg_master_ns,
   input logic cfg_err_resp,
   input logic irq_clr,
   input logic irq,
   input logic attr_exempt,
   input logic attr_nonsec,
   input logic up_req,
   input logic up_ready,
   input logic up_rsp_valid,
   input logic up_err,
   input logic dn_req,
   input logic dn_secure
);
   logic acc;
   logic sec_blk;
   assign acc     = up_req && up_ready;
   assign sec_blk = acc && !attr_exempt && !attr_nonsec && cfg_master_ns;

   a_r1_exempt_attr: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && attr_exempt) |=> (dn_req && (dn_secure == !$past(cfg_master_ns))));

   a_r2_ns_region: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !attr_exempt && attr_nonsec) |=> (dn_req && !dn_secure));

   a_r3_sec_master: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !attr_exempt && !attr_nonsec && !cfg_master_ns) |=> (dn_req && dn_secure));

   a_r4_razwi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_blk && !cfg_err_resp) |=> (!dn_req && up_rsp_valid && !up_err && (irq == $past(irq))));

   a_r5_abort_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_blk && cfg_err_resp && !irq_clr) |=> (!dn_req && up_err && irq));

   a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |=> !irq);

   a_r10_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req || up_rsp_valid) |-> !up_ready);
endmodule

bind master_sec_filter msf_checker u_msf_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_master_ns (cfg_master_ns),
   .cfg_err_resp  (cfg_err_resp),
   .irq_clr       (irq_clr),
   .irq           (irq),
   .attr_exempt   (attr_exempt),
   .attr_nonsec   (attr_nonsec),
   .up_req        (up_req),
   .up_ready      (up_ready),
   .up_rsp_valid  (up_rsp_valid),
   .up_err        (up_err),
   .dn_req        (dn_req),
   .dn_secure     (dn_secure)
);

// File: tb/master_sec_filter_bench.sv
module master_sec_filter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_master_ns = 1'b0, cfg_err_resp = 1'b0, irq_clr = 1'b0;
   logic        irq;
   logic        attr_exempt = 1'b0, attr_nonsec = 1'b0;
   logic        up_req = 1'b0, up_ready, up_wr = 1'b0;
   logic [31:0] up_addr = '0;
   logic [1:0]  up_size = '0;
   logic [63:0] up_wdata = '0;
   logic        up_rsp_valid, up_err;
   logic [63:0] up_rdata;
   logic        dn_req, dn_wr, dn_secure;
   logic [31:0] dn_addr;
   logic [1:0]  dn_size;
   logic [63:0] dn_wdata;
   logic        dn_rsp_valid = 1'b0, dn_err = 1'b0;
   logic [63:0] dn_rdata = '0;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   logic exp_irq = 1'b0;

   always #5 clk = ~clk;

   master_sec_filter u_master_sec_filter (.*);

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         failures++;
         $display("FAIL watchdog expired: actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] lanes(input logic [63:0] d, input int sz);
      logic [63:0] r = '0;
      for (int b = 0; b < 8; b++)
         if (b < (1 << sz)) r[b*8 +: 8] = d[b*8 +: 8];
      return r;
   endfunction

   task automatic access(input logic ex, input logic ns, input logic mns, input logic er,
                         input logic wr, input int sz, input logic [31:0] a,
                         input logic [63:0] wd, input logic clr);
      logic fwd, sec, abort;
      logic [63:0] rd;
      fwd   = ex || ns || !mns;
      sec   = ex ? !mns : (!ns && !mns);
      abort = !fwd && er;
      rd    = {a ^ 32'hA5A5_0000, ~a};
      attr_exempt = ex; attr_nonsec = ns; cfg_master_ns = mns; cfg_err_resp = er;
      up_wr = wr; up_size = 2'(sz); up_addr = a; up_wdata = wd; irq_clr = clr;
      up_req = 1'b1;
      @(negedge clk);
      up_req = 1'b0; irq_clr = 1'b0;
      if (clr) exp_irq = 1'b0;
      else if (abort) exp_irq = 1'b1;
      chk("R6 irq after accept", 64'(irq), 64'(exp_irq));
      chk("R10 ready low after accept", 64'(up_ready), 64'd0);
      if (!fwd) begin
         chk("R4/R5 no downstream request", 64'(dn_req), 64'd0);
         chk("R4/R5 response pulse", 64'(up_rsp_valid), 64'd1);
         chk(er ? "R5 error flag" : "R4 error flag", 64'(up_err), 64'(er));
         if (!er) chk("R4 read zero", up_rdata, 64'd0);
      end else begin
         chk("R10 dn_req raised", 64'(dn_req), 64'd1);
         chk(ex ? "R1 secure attr" : (ns ? "R2 secure attr" : "R3 secure attr"),
             64'(dn_secure), 64'(sec));
         chk("R8 addr pass", 64'(dn_addr), 64'(a));
         chk("R8 wr pass", 64'(dn_wr), 64'(wr));
         chk("R8 size pass", 64'(dn_size), 64'(sz));
         chk("R8 wdata lanes", dn_wdata, lanes(wd, sz));
         @(negedge clk);
         chk("R10 dn_req held", 64'(dn_req), 64'd1);
         dn_rsp_valid = 1'b1; dn_rdata = rd; dn_err = a[4];
         @(negedge clk);
         dn_rsp_valid = 1'b0;
         chk("R9 response pulse", 64'(up_rsp_valid), 64'd1);
         chk("R9 error pass", 64'(up_err), 64'(a[4]));
         chk("R8 rdata lanes", up_rdata, lanes(rd, sz));
         chk("R10 dn_req dropped", 64'(dn_req), 64'd0);
      end
      @(negedge clk);
      chk("R10 ready again", 64'(up_ready), 64'd1);
      chk("R6 irq sticky", 64'(irq), 64'(exp_irq));
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      chk("R7 irq reset", 64'(irq), 64'd0);
      chk("R7 ready reset", 64'(up_ready), 64'd1);
      chk("R7 dn_req reset", 64'(dn_req), 64'd0);
      chk("R7 rsp reset", 64'(up_rsp_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int combo = 0; combo < 16; combo++)
         for (int wr = 0; wr < 2; wr++)
            for (int sz = 0; sz < 4; sz++) begin
               logic [31:0] a;
               a = 32'h1000_0000 + 32'(combo * 64 + wr * 16 + sz * 40);
               access(combo[3], combo[2], combo[1], combo[0], wr[0], sz, a,
                      {a, ~a} ^ 64'h0123_4567_89AB_CDEF, 1'b0);
               if (exp_irq) begin
                  irq_clr = 1'b1;
                  @(negedge clk);
                  irq_clr = 1'b0; exp_irq = 1'b0;
                  chk("R6 clear", 64'(irq), 64'd0);
               end
            end

      // R5/R6: clear held high while an error-mode violation is accepted
      access(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3, 32'h2000_0000, 64'h0, 1'b1);
      chk("R6 clear beats violation", 64'(irq), 64'd0);

      // R6: flag survives forwarded traffic until cleared
      access(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2, 32'h2000_0040, 64'h55, 1'b0);
      access(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1, 32'h2000_0080, 64'h0, 1'b0);
      access(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0, 32'h2000_00C0, 64'hFFFF, 1'b0);
      chk("R6 still set", 64'(irq), 64'd1);
      // R4: silent refusal leaves the flag alone
      access(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3, 32'h2000_0100, 64'h0, 1'b0);
      chk("R4 irq untouched", 64'(irq), 64'd1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0; exp_irq = 1'b0;
      chk("R6 cleared", 64'(irq), 64'd0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule